// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Engine

This block is the receive half of a single DMA channel. A byte stream arrives on a valid/ready interface, and a flag on the final byte marks the end of each packet. The engine places each byte in the buffer named by the current data descriptor. It packs adjacent bytes into one memory word and uses byte enables so that bytes outside the buffer are never overwritten. A descriptor closes when its buffer fills or when the packet ends. On close, the engine writes back the true fill point and a packet-end mark. It then follows the chain to the next descriptor, or it halts the channel when the closed descriptor carries the last-in-list mark.

Software gives the engine a pulse together with the address of the first descriptor and the address of the channel context word. The engine stays busy until it reaches the last descriptor in the list. A descriptor occupies four words: the link to the next descriptor at +0, the buffer start at +4, the flags at +8 and the buffer end pointer at +12. Interrupt causes collect in a sticky register. Each cause bit stays set until its acknowledge bit clears it.

Top module: `rxdma_engine`

## Requirements
- R1: After reset, s_ready_o, mem_req_o, eol_o and irq_o are low and cause_o is zero.
- R2: A start pulse makes the engine read the descriptor words at D, D+4, D+8 and D+12, in that order, where D is the descriptor address. Every memory request is held, with a stable address, until it is acknowledged.
- R3: Received bytes are stored at consecutive byte addresses from the buffer start. Byte lane k of a word carries address offset k, and only the lanes that were filled are enabled. A word is written when its last lane fills or when the descriptor closes. The engine never accepts a byte while a memory request is pending.
- R4: The write position never reaches past the end pointer. When the buffer becomes full, the descriptor closes and the next byte goes to the following descriptor.
- R5: On close, the word at D+12 is overwritten with the final write position.
- R6: On close, the flags word at D+8 is written back with all its bits unchanged, except that bit 11 is set exactly when the close was caused by a packet end. A byte that both fills the buffer and ends the packet counts as a packet end.
- R7: When a closing descriptor has flag bit 4 set, cause bits 0 and 1 are both set.
- R8: A close caused by a packet end sets cause bit 3.
- R9: Cause bits are sticky and clear only through cause_ack_i. irq_o is the OR of cause_o ANDed with irq_mask_i, and it is recomputed only in a cycle where the cause register changes. A change of the mask alone leaves irq_o unchanged.
- R10: When a closing descriptor has flag bit 0 set, the engine writes 0x00008000 to the context address with only byte lane 1 enabled (bit 15 set, lane bits 8 to 14 cleared). It then raises eol_o and keeps s_ready_o low until the next start pulse.
- R11: When a closing descriptor has flag bit 0 clear, the engine loads the descriptor at the address held in word +0 and continues writing at that descriptor's buffer start.
- R12: Before the first start pulse, s_ready_o stays low whatever the stream input does.
- R13: A descriptor whose buffer start equals its end pointer closes as soon as it is loaded, without a packet-end mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle or halted |
| desc_i | input | DW | Address of the first descriptor |
| ctx_i | input | DW | Address of the context word |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | This byte ends the packet |
| s_ready_o | output | 1 | Engine accepts a byte |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | DW | Word-aligned byte address |
| mem_wdata_o | output | DW | Write data |
| mem_be_o | output | DW/8 | Write byte enables |
| mem_ack_i | input | 1 | Request done; read data valid in this cycle |
| mem_rdata_i | input | DW | Read data |
| irq_mask_i | input | 4 | Interrupt enable per cause bit |
| cause_ack_i | input | 4 | Clear cause bits |
| cause_o | output | 4 | Sticky interrupt causes |
| irq_o | output | 1 | Registered interrupt line |
| eol_o | output | 1 | Channel halted at end of list |

## Verification
The bench applies every input at a falling edge and samples the outputs at a later falling edge. cause_o and irq_o settle on the clock edge that acknowledges the end-pointer write-back. eol_o rises one memory handshake later, after the context write. For that reason the final memory image, the causes and the line are all compared once eol_o has been seen high, and never at a fixed cycle count. Memory latency varies from run to run, so none of these checks relies on an exact cycle. Stall and mask checks hold their stimulus for several cycles and then read the outputs, because a handshake output here responds one edge after its cause.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_STREAM, S_FLUSH, S_WBFLG, S_WBEND, S_WBCTX, S_EOL
  } rx_state_e;

  localparam int FLG_LAST_DESC = 0;
  localparam int FLG_IRQ_REQ   = 4;
  localparam int FLG_PKT_END   = 11;
  localparam int CTX_HALT      = 15;

  localparam int CAUSE_W    = 4;
  localparam int CAUSE_D0   = 0;
  localparam int CAUSE_D1   = 1;
  localparam int CAUSE_PKT  = 3;
endpackage

// File: rtl/rxdma_pack.sv
module rxdma_pack #(
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [$clog2(DW/8)-1:0] lane_i,
  input  logic [7:0]              byte_i,
  input  logic                    clr_i,
  output logic [DW-1:0]           word_o,
  output logic [DW/8-1:0]         be_o
);
  localparam int LANES = DW / 8;
  localparam int LSB   = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       hit;
    logic [7:0] dat_q, dat_d;
    logic       en_q, en_d;

    assign hit = wr_i && (lane_i == LSB'(g));

    always_comb begin
      dat_d = dat_q;
      en_d  = en_q;
      if (clr_i) en_d = 1'b0;
      if (hit) begin
        dat_d = byte_i;
        en_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= '0;
        en_q  <= 1'b0;
      end else begin
        dat_q <= dat_d;
        en_q  <= en_d;
      end
    end

    assign word_o[8*g +: 8] = dat_q;
    assign be_o[g]          = en_q;
  end
endmodule

// File: rtl/rxdma_cause.sv
module rxdma_cause
  import rxdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic [CAUSE_W-1:0] ack_i,
  input  logic [CAUSE_W-1:0] mask_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               irq_q, irq_d;

  always_comb begin
    cause_d = (cause_q & ~ack_i) | set_i;
    irq_d   = irq_q;
    if (cause_d != cause_q) irq_d = |(cause_d & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= irq_d;
    end
  end

  assign cause_o = cause_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
  import rxdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DW-1:0]      desc_i,
  input  logic [DW-1:0]      ctx_i,
  input  logic               s_valid_i,
  input  logic [7:0]         s_data_i,
  input  logic               s_last_i,
  output logic               s_ready_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [DW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  output logic [DW/8-1:0]    mem_be_o,
  input  logic               mem_ack_i,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic [CAUSE_W-1:0] irq_mask_i,
  input  logic [CAUSE_W-1:0] cause_ack_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o,
  output logic               eol_o
);
  localparam int LANES = DW / 8;
  localparam int LSB   = $clog2(LANES);

  rx_state_e     state_q, state_d;
  logic [DW-1:0] dptr_q, dptr_d, ctx_q, ctx_d, next_q, next_d;
  logic [DW-1:0] flags_q, flags_d, end_q, end_d, pos_q, pos_d, faddr_q, faddr_d;
  logic [1:0]    widx_q, widx_d;
  logic          eop_q, eop_d, closing_q, closing_d;

  logic [DW-1:0]      pos_inc;
  logic               accept, pack_clr;
  logic [DW-1:0]      pack_word;
  logic [LANES-1:0]   pack_be;
  logic [CAUSE_W-1:0] cause_set;

  assign s_ready_o = (state_q == S_STREAM);
  assign eol_o     = (state_q == S_EOL);
  assign accept    = s_valid_i && s_ready_o;
  assign pos_inc   = pos_q + DW'(1);

  always_comb begin
    state_d = state_q; dptr_d = dptr_q; ctx_d = ctx_q; next_d = next_q;
    flags_d = flags_q; end_d = end_q; pos_d = pos_q; faddr_d = faddr_q;
    widx_d = widx_q; eop_d = eop_q; closing_d = closing_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = '0; mem_wdata_o = '0;
    mem_be_o = '0; pack_clr = 1'b0; cause_set = '0;
    case (state_q)
      S_IDLE, S_EOL: begin
        if (start_i) begin
          dptr_d  = desc_i;
          ctx_d   = ctx_i;
          widx_d  = 2'd0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dptr_q + DW'({widx_q, {LSB{1'b0}}});
        if (mem_ack_i) begin
          case (widx_q)
            2'd0: next_d  = mem_rdata_i;
            2'd1: pos_d   = mem_rdata_i;
            2'd2: flags_d = mem_rdata_i;
            default: end_d = mem_rdata_i;
          endcase
          widx_d = widx_q + 2'd1;
          if (widx_q == 2'd3) begin
            eop_d   = 1'b0;
            state_d = (pos_q == mem_rdata_i) ? S_WBFLG : S_STREAM;
          end
        end
      end
      S_STREAM: begin
        if (s_valid_i) begin
          pos_d   = pos_inc;
          faddr_d = {pos_q[DW-1:LSB], {LSB{1'b0}}};
          if (s_last_i || (pos_inc == end_q)) begin
            closing_d = 1'b1;
            eop_d     = s_last_i;
            state_d   = S_FLUSH;
          end else if (pos_inc[LSB-1:0] == '0) begin
            closing_d = 1'b0;
            state_d   = S_FLUSH;
          end
        end
      end
      S_FLUSH: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = faddr_q;
        mem_wdata_o = pack_word;
        mem_be_o    = pack_be;
        if (mem_ack_i) begin
          pack_clr = 1'b1;
          state_d  = closing_q ? S_WBFLG : S_STREAM;
        end
      end
      S_WBFLG: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dptr_q + DW'(2 * LANES);
        mem_wdata_o = flags_q;
        mem_wdata_o[FLG_PKT_END] = flags_q[FLG_PKT_END] | eop_q;
        mem_be_o    = '1;
        if (mem_ack_i) state_d = S_WBEND;
      end
      S_WBEND: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dptr_q + DW'(3 * LANES);
        mem_wdata_o = pos_q;
        mem_be_o    = '1;
        if (mem_ack_i) begin
          cause_set[CAUSE_D0]  = flags_q[FLG_IRQ_REQ];
          cause_set[CAUSE_D1]  = flags_q[FLG_IRQ_REQ];
          cause_set[CAUSE_PKT] = eop_q;
          if (flags_q[FLG_LAST_DESC]) begin
            state_d = S_WBCTX;
          end else begin
            dptr_d  = next_q;
            widx_d  = 2'd0;
            state_d = S_FETCH;
          end
        end
      end
      S_WBCTX: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_q;
        mem_wdata_o = DW'(1) << CTX_HALT;
        mem_be_o    = LANES'(1) << (CTX_HALT / 8);
        if (mem_ack_i) state_d = S_EOL;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; dptr_q <= '0; ctx_q <= '0; next_q <= '0;
      flags_q <= '0; end_q <= '0; pos_q <= '0; faddr_q <= '0;
      widx_q <= '0; eop_q <= 1'b0; closing_q <= 1'b0;
    end else begin
      state_q <= state_d; dptr_q <= dptr_d; ctx_q <= ctx_d; next_q <= next_d;
      flags_q <= flags_d; end_q <= end_d; pos_q <= pos_d; faddr_q <= faddr_d;
      widx_q <= widx_d; eop_q <= eop_d; closing_q <= closing_d;
    end
  end

  rxdma_pack #(.DW(DW)) u_pack (
    .clk(clk), .rst_n(rst_n), .wr_i(accept), .lane_i(pos_q[LSB-1:0]),
    .byte_i(s_data_i), .clr_i(pack_clr), .word_o(pack_word), .be_o(pack_be)
  );

  rxdma_cause u_cause (
    .clk(clk), .rst_n(rst_n), .set_i(cause_set), .ack_i(cause_ack_i),
    .mask_i(irq_mask_i), .cause_o(cause_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/rxdma_engine_chk.sv
module rxdma_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          s_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic [3:0]    cause_ack_i,
  input logic [3:0]    cause_o,
  input logic          irq_o,
  input logic          eol_o
);
  a_r10_no_ready_at_eol: assert property (@(posedge clk) disable iff (!rst_n)
    eol_o |-> !s_ready_o);

  a_r10_eol_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (eol_o && !start_i) |=> eol_o);

  a_r9_irq_follows_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_o) |-> !$stable(cause_o));

  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(cause_o) & ~$past(cause_ack_i)) & ~cause_o) == 4'b0000));

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r3_ready_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> !mem_req_o);
endmodule

bind rxdma_engine rxdma_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .s_ready_o(s_ready_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_ack_i(mem_ack_i), .cause_ack_i(cause_ack_i), .cause_o(cause_o),
  .irq_o(irq_o), .eol_o(eol_o)
);

// File: tb/tb_rxdma_engine.sv
module tb_rxdma_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] desc_i, ctx_i;
  logic        s_valid_i, s_last_i;
  logic [7:0]  s_data_i;
  logic        s_ready_o, mem_req_o, mem_we_o, mem_ack_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  mem_be_o, irq_mask_i, cause_ack_i, cause_o;
  logic        irq_o, eol_o;

  always #5 clk = ~clk;

  rxdma_engine #(.DW(32)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_i(desc_i), .ctx_i(ctx_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
    .s_ready_o(s_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .irq_mask_i(irq_mask_i),
    .cause_ack_i(cause_ack_i), .cause_o(cause_o), .irq_o(irq_o), .eol_o(eol_o)
  );

  localparam int D0 = 32'h100, D1 = 32'h110, CTX = 32'h1F0;

  logic [7:0] mem [0:1023];
  logic [7:0] exm [0:1023];
  logic [7:0] sb [0:15];
  logic       sl [0:15];
  int checks = 0, fails = 0, cycles = 0;
  int lat_base = 0, rd_cnt = 0, wr_cnt = 0;
  int rd_log [0:3];
  logic [3:0] exp_cause;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // memory responder: acts at falling edges
  initial begin
    int lat;
    mem_ack_i = 1'b0; mem_rdata_i = '0; lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_req_o && rst_n) begin
        if (lat > 0) lat--;
        else begin
          int a;
          a = int'(mem_addr_o[9:0]);
          if (mem_we_o) begin
            wr_cnt++;
            for (int b = 0; b < 4; b++)
              if (mem_be_o[b]) mem[a+b] = mem_wdata_o[8*b +: 8];
          end else begin
            mem_rdata_i = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
            if (rd_cnt < 4) rd_log[rd_cnt] = a;
            rd_cnt++;
          end
          mem_ack_i = 1'b1;
          lat = lat_base;
        end
      end
    end
  end

  function automatic logic [31:0] exr(input int a);
    return {exm[a+3], exm[a+2], exm[a+1], exm[a]};
  endfunction

  function automatic logic [31:0] mr(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic exw(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) exm[a+b] = v[8*b +: 8];
  endtask

  task automatic put(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) begin
      exm[a+b] = v[8*b +: 8];
      mem[a+b] = v[8*b +: 8];
    end
  endtask

  // expected behaviour from the requirements, at transaction level
  task automatic model(input int d0, input int nb);
    int d, idx;
    bit done, e;
    logic [31:0] nx, fl, af, pos;
    d = d0; idx = 0; done = 0;
    while (!done) begin
      nx = exr(d); pos = exr(d+4); fl = exr(d+8); af = exr(d+12);
      e = 0;
      while (pos != af && idx < nb) begin
        exm[pos[9:0]] = sb[idx];
        pos = pos + 1;
        e = sl[idx];
        idx++;
        if (e) break;
      end
      if (pos != af && !e) begin
        done = 1;
      end else begin
        exw(d+8, fl | (32'(e) << 11));
        exw(d+12, pos);
        exp_cause = exp_cause | (fl[4] ? 4'b0011 : 4'b0000) | (e ? 4'b1000 : 4'b0000);
        if (fl[0]) begin
          exm[CTX+1] = 8'h80;
          done = 1;
        end else d = int'(nx);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic l);
    int guard;
    s_valid_i = 1'b1; s_data_i = d; s_last_i = l;
    guard = 0;
    while (!s_ready_o && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_region(input int lo, input int hi, input string tag);
    int bad, first;
    bad = 0; first = -1;
    for (int a = lo; a < hi; a++)
      if (mem[a] !== exm[a]) begin
        bad++;
        if (first < 0) first = a;
      end
    if (first < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, {first[15:0], 8'h00, mem[first]}, {first[15:0], 8'h00, exm[first]});
  endtask

  task automatic run_case(input int off, input int sz, input int plen, input bit do_ack);
    int b0, b1, nb, guard;
    bit i0, i1;
    for (int a = 0; a < 1024; a++) begin
      mem[a] = 8'(a * 5 + 3);
      exm[a] = 8'(a * 5 + 3);
    end
    b0 = 32'h200 + off;
    b1 = 32'h280 + ((off + 1) % 4);
    i0 = 1'((plen + sz) % 2);
    i1 = 1'(off % 2);
    put(D0, D1); put(D0+4, b0); put(D0+8, 32'h4 | (32'(i0) << 4)); put(D0+12, b0 + sz);
    put(D1, 32'h120); put(D1+4, b1); put(D1+8, 32'h41 | (32'(i1) << 4)); put(D1+12, b1 + 8);
    nb = plen + ((plen <= sz) ? 2 : 0);
    for (int i = 0; i < nb; i++) begin
      sb[i] = 8'(i * 37 + off * 11 + sz);
      sl[i] = (i == plen - 1) || (i == nb - 1);
    end
    exp_cause = 4'b0000;
    model(D0, nb);
    lat_base = (off + plen) % 3;
    rd_cnt = 0;
    start_i = 1'b1; desc_i = D0; ctx_i = CTX;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < nb; i++) send_byte(sb[i], sl[i]);
    s_valid_i = 1'b0; s_last_i = 1'b0;
    guard = 0;
    while (!eol_o && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk(eol_o === 1'b1, "R10 eol_o raised", 32'(eol_o), 1);
    chk(rd_log[0] == D0 && rd_log[1] == D0+4 && rd_log[2] == D0+8 && rd_log[3] == D0+12,
        "R2 descriptor read order", rd_log[2], D0+8);
    cmp_region(32'h200, 32'h300, "R3 R4 R11 buffer bytes");
    chk(mr(D0+12) == exr(D0+12), "R5 R4 end pointer rewrite desc0", mr(D0+12), exr(D0+12));
    chk(mr(D1+12) == exr(D1+12), "R5 R11 end pointer rewrite desc1", mr(D1+12), exr(D1+12));
    chk(mr(D0+8) == exr(D0+8), "R6 flags write-back desc0", mr(D0+8), exr(D0+8));
    chk(mr(D1+8) == exr(D1+8), "R6 flags write-back desc1", mr(D1+8), exr(D1+8));
    chk(mr(CTX) == exr(CTX), "R10 context halt word", mr(CTX), exr(CTX));
    if (sz == 0) chk(mr(D0+12) == b0 && mr(D0+8) == exr(D0+8) && !mr(D0+8)[11],
                     "R13 empty descriptor close", mr(D0+12), b0);
    chk(cause_o == exp_cause, "R7 R8 cause bits", 32'(cause_o), 32'(exp_cause));
    chk(irq_o == |(exp_cause & irq_mask_i), "R9 irq line", 32'(irq_o), 32'(|(exp_cause & irq_mask_i)));
    if (do_ack) begin
      cause_ack_i = 4'hF;
      @(negedge clk);
      cause_ack_i = 4'h0;
      chk(cause_o == 4'h0, "R9 ack clears causes", 32'(cause_o), 0);
    end
  endtask

  initial begin
    int rcnt, w0;
    rst_n = 1'b0; start_i = 1'b0; desc_i = '0; ctx_i = '0;
    s_valid_i = 1'b0; s_data_i = '0; s_last_i = 1'b0;
    irq_mask_i = 4'b0000; cause_ack_i = 4'b0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_ready_o && !mem_req_o, "R1 reset ready and request", {s_ready_o, mem_req_o}, 0);
    chk(cause_o == 0 && !irq_o, "R1 reset causes and irq", {cause_o, irq_o}, 0);
    chk(!eol_o, "R1 reset eol", 32'(eol_o), 0);

    // R12: stream offered before any start
    rcnt = 0; w0 = wr_cnt;
    s_valid_i = 1'b1; s_data_i = 8'h5A; s_last_i = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (s_ready_o) rcnt++;
    end
    s_valid_i = 1'b0; s_last_i = 1'b0;
    chk(rcnt == 0 && wr_cnt == w0, "R12 idle ignores stream", rcnt, 0);

    irq_mask_i = 4'b1000;
    for (int off = 0; off < 4; off++)
      for (int sz = 0; sz < 6; sz++)
        for (int plen = 1; plen < 8; plen++)
          run_case(off, sz, plen, 1'b1);

    // R10: halted channel stalls the stream
    rcnt = 0; w0 = wr_cnt;
    s_valid_i = 1'b1; s_data_i = 8'hC3; s_last_i = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (s_ready_o) rcnt++;
    end
    s_valid_i = 1'b0;
    chk(rcnt == 0 && wr_cnt == w0 && eol_o, "R10 stall at end of list", rcnt, 0);
    cmp_region(32'h100, 32'h300, "R10 memory untouched after halt");

    // R9: mask change alone does not move irq; cause change re-evaluates it
    run_case(1, 2, 4, 1'b0);
    chk(irq_o == 1'b1 && cause_o == 4'b1011, "R9 irq set by causes", {cause_o, irq_o}, {4'b1011, 1'b1});
    irq_mask_i = 4'b0000;
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, "R9 mask change alone ignored", 32'(irq_o), 1);
    cause_ack_i = 4'b0001;
    @(negedge clk);
    cause_ack_i = 4'b0000;
    chk(irq_o == 1'b0 && cause_o == 4'b1010, "R9 re-evaluated on cause change", {cause_o, irq_o}, {4'b1010, 1'b0});
    irq_mask_i = 4'b1000;
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b0, "R9 unmask alone ignored", 32'(irq_o), 0);
    cause_ack_i = 4'hF;
    @(negedge clk);
    cause_ack_i = 4'h0;
    chk(cause_o == 0 && irq_o == 0, "R9 full ack", {cause_o, irq_o}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule